// File: doc/BRIEF.md
# Shared interrupt combiner

The combiner gathers interrupt requests from a set of peripheral sources and presents a single upstream interrupt line. Each source owns one bit in each of three registers: an enable register, a read-only status register and a write-to-acknowledge clear register. A request pulse from a source latches its status bit. The bit stays set until software acknowledges it. The upstream line is raised while any valid, enabled status bit is pending.

Parameters fix the behaviour for each instance. They set the number of sources, the polarity of enable bits and the polarity of acknowledge bits. A valid mask names the status bits that can take part at all. Two presence masks mark the sources that have no enable bit or no acknowledge bit. A source without an enable bit is always enabled. A source without an acknowledge bit reports its request level, so its status falls only when the peripheral withdraws the request.

Top module: `irqc_combiner`

## Requirements
- R1: After reset every status bit is 0, the interrupt output is 0 and the enable register holds the masking level in every bit: all ones when enables are active low, all zeros otherwise.
- R2: For a valid source that has an acknowledge bit, a request high at a clock edge sets its status bit at that edge. The bit stays set until it is acknowledged.
- R3: With ENA_ACTIVE_LOW = 1 a 0 in a source's enable bit enables it and a 1 masks it; with ENA_ACTIVE_LOW = 0 a 1 enables it. A write to address 0 loads the enable register, and a read of address 0 returns it.
- R4: A write to address 2 acknowledges each source whose bit is 0 when CLR_ON_ZERO = 1, or whose bit is 1 when CLR_ON_ZERO = 0. Bits at the other level have no effect.
- R5: When an acknowledge and a new request for the same source arrive in the same cycle, its status bit stays set.
- R6: A source outside VALID_MASK never sets its status bit and never raises the interrupt output.
- R7: A source whose HAS_ENA bit is 0 is always enabled. Its enable bit ignores writes and reads back at the masking level.
- R8: A valid source whose HAS_CLR bit is 0 shows, in its status bit, its request level registered at the previous edge. Acknowledge writes do not affect it.
- R9: The interrupt output equals, one cycle later, the OR over all sources of status AND effective enable AND valid mask.
- R10: With several sources pending, the output stays high until every valid, enabled pending bit has been cleared.
- R11: The status register is read at address 1. A read of address 2 returns the inactive acknowledge level for sources with an acknowledge bit and 0 for the others. A read of address 3 returns 0. A write to address 1 or 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_req_i | input | NSRC | Request from each source, bit b for source b |
| reg_wr_i | input | 1 | Register write strobe |
| reg_waddr_i | input | 2 | Write address: 0 enable, 1 status, 2 acknowledge, 3 unused |
| reg_wdata_i | input | NSRC | Write data, bit b for source b |
| reg_raddr_i | input | 2 | Read address, decoded the same way as the write address |
| reg_rdata_o | output | NSRC | Read data, combinational from the read address |
| irq_o | output | 1 | Combined upstream interrupt, registered |

## Verification
The bench builds eight sources with active-low enables and acknowledge-on-zero. Source 1 has no enable bit, source 6 has no acknowledge bit and source 7 is left out of the valid mask. This single build reaches the inverted polarities, the always-enabled source, the level-following status and a masked source that must stay silent under heavy random requests. Directed sequences cover these bits, and a same-cycle acknowledge and request. Long random runs of requests, writes and reads then test the remaining combinations against a reference model.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    typedef enum logic [1:0] {
        REG_ENA  = 2'd0,
        REG_STAT = 2'd1,
        REG_ACK  = 2'd2,
        REG_NONE = 2'd3
    } irqc_reg_e;
endpackage

// File: rtl/irqc_enable_reg.sv
module irqc_enable_reg #(
    parameter int              NSRC           = 8,
    parameter logic [NSRC-1:0] HAS_ENA        = {NSRC{1'b1}},
    parameter bit              ENA_ACTIVE_LOW = 1'b0
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            wr_i,
    input  logic [NSRC-1:0] wdata_i,
    output logic [NSRC-1:0] raw_o,
    output logic [NSRC-1:0] eff_o
);
    localparam logic [NSRC-1:0] MASK_LVL = ENA_ACTIVE_LOW ? {NSRC{1'b1}} : {NSRC{1'b0}};

    typedef struct packed {
        logic [NSRC-1:0] ena;
    } ena_state_t;

    ena_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_i) begin
            s_d.ena = (wdata_i & HAS_ENA) | (MASK_LVL & ~HAS_ENA);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '{ena: MASK_LVL};
        else         s_q <= s_d;
    end

    assign raw_o = s_q.ena;

    generate
        if (ENA_ACTIVE_LOW) begin : g_low
            assign eff_o = ~s_q.ena | ~HAS_ENA;
        end else begin : g_high
            assign eff_o = s_q.ena | ~HAS_ENA;
        end
    endgenerate
endmodule

// File: rtl/irqc_status_bank.sv
module irqc_status_bank #(
    parameter int              NSRC       = 8,
    parameter logic [NSRC-1:0] VALID_MASK = {NSRC{1'b1}},
    parameter logic [NSRC-1:0] HAS_CLR    = {NSRC{1'b1}}
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [NSRC-1:0] req_i,
    input  logic [NSRC-1:0] ack_i,
    output logic [NSRC-1:0] st_o
);
    logic [NSRC-1:0] st_d, st_q;

    always_comb begin
        for (int b = 0; b < NSRC; b++) begin
            if (!VALID_MASK[b])  st_d[b] = 1'b0;
            else if (HAS_CLR[b]) st_d[b] = (st_q[b] & ~ack_i[b]) | req_i[b];
            else                 st_d[b] = req_i[b];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign st_o = st_q;

    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_chk
            if (VALID_MASK[g] && HAS_CLR[g]) begin : g_latch
                p_set_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
                    req_i[g] |=> st_o[g]);
                p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
                    (st_o[g] && !ack_i[g]) |=> st_o[g]);
                p_ack_drops_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
                    (ack_i[g] && !req_i[g]) |=> !st_o[g]);
            end else if (VALID_MASK[g]) begin : g_level
                p_follow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
                    1'b1 |=> (st_o[g] == $past(req_i[g])));
            end else begin : g_dead
                p_invalid_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
                    req_i[g] |=> !st_o[g]);
            end
        end
    endgenerate
endmodule

// File: rtl/irqc_merge.sv
module irqc_merge #(
    parameter int              NSRC       = 8,
    parameter logic [NSRC-1:0] VALID_MASK = {NSRC{1'b1}}
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [NSRC-1:0] st_i,
    input  logic [NSRC-1:0] en_i,
    output logic            irq_o
);
    logic irq_d, irq_q;

    always_comb begin
        irq_d = |(st_i & en_i & VALID_MASK);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) irq_q <= 1'b0;
        else         irq_q <= irq_d;
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/irqc_combiner.sv
module irqc_combiner
    import irqc_pkg::*;
#(
    parameter int              NSRC           = 8,
    parameter logic [NSRC-1:0] VALID_MASK     = {NSRC{1'b1}},
    parameter logic [NSRC-1:0] HAS_ENA        = {NSRC{1'b1}},
    parameter logic [NSRC-1:0] HAS_CLR        = {NSRC{1'b1}},
    parameter bit              ENA_ACTIVE_LOW = 1'b0,
    parameter bit              CLR_ON_ZERO    = 1'b0
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [NSRC-1:0] src_req_i,
    input  logic            reg_wr_i,
    input  logic [1:0]      reg_waddr_i,
    input  logic [NSRC-1:0] reg_wdata_i,
    input  logic [1:0]      reg_raddr_i,
    output logic [NSRC-1:0] reg_rdata_o,
    output logic            irq_o
);
    localparam logic [NSRC-1:0] ACK_IDLE = (CLR_ON_ZERO ? {NSRC{1'b1}} : {NSRC{1'b0}}) & HAS_CLR;

    logic            ena_wr;
    logic [NSRC-1:0] ack;
    logic [NSRC-1:0] ena_raw, ena_eff, status;

    always_comb begin
        ena_wr = reg_wr_i && (irqc_reg_e'(reg_waddr_i) == REG_ENA);
        ack    = '0;
        if (reg_wr_i && (irqc_reg_e'(reg_waddr_i) == REG_ACK)) begin
            ack = (CLR_ON_ZERO ? ~reg_wdata_i : reg_wdata_i) & HAS_CLR;
        end
    end

    irqc_enable_reg #(
        .NSRC(NSRC), .HAS_ENA(HAS_ENA), .ENA_ACTIVE_LOW(ENA_ACTIVE_LOW)
    ) i_ena (
        .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(ena_wr), .wdata_i(reg_wdata_i),
        .raw_o(ena_raw), .eff_o(ena_eff)
    );

    irqc_status_bank #(
        .NSRC(NSRC), .VALID_MASK(VALID_MASK), .HAS_CLR(HAS_CLR)
    ) i_stat (
        .clk_i(clk_i), .rst_ni(rst_ni), .req_i(src_req_i), .ack_i(ack), .st_o(status)
    );

    irqc_merge #(
        .NSRC(NSRC), .VALID_MASK(VALID_MASK)
    ) i_merge (
        .clk_i(clk_i), .rst_ni(rst_ni), .st_i(status), .en_i(ena_eff), .irq_o(irq_o)
    );

    always_comb begin
        unique case (irqc_reg_e'(reg_raddr_i))
            REG_ENA:  reg_rdata_o = ena_raw;
            REG_STAT: reg_rdata_o = status;
            REG_ACK:  reg_rdata_o = ACK_IDLE;
            default:  reg_rdata_o = '0;
        endcase
    end

    p_irq_tracks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (irq_o == $past(|(status & ena_eff & VALID_MASK))));
    p_pending_holds_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(status & ena_eff & VALID_MASK)) |=> irq_o);
endmodule

// File: tb/test_irqc_combiner.sv
module test_irqc_combiner;
    localparam int              NSRC   = 8;
    localparam logic [NSRC-1:0] VALID  = 8'h7F;
    localparam logic [NSRC-1:0] H_ENA  = 8'hFD;
    localparam logic [NSRC-1:0] H_CLR  = 8'hBF;
    localparam bit              E_LOW  = 1'b1;
    localparam bit              C_ZERO = 1'b1;
    localparam logic [NSRC-1:0] MASKV  = E_LOW ? 8'hFF : 8'h00;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] req = '0;
    logic            wr = 1'b0;
    logic [1:0]      waddr = '0;
    logic [NSRC-1:0] wdata = '0;
    logic [1:0]      raddr = '0;
    logic [NSRC-1:0] rdata;
    logic            irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [NSRC-1:0] m_ena, m_st;
    logic            m_irq;

    irqc_combiner #(
        .NSRC(NSRC), .VALID_MASK(VALID), .HAS_ENA(H_ENA), .HAS_CLR(H_CLR),
        .ENA_ACTIVE_LOW(E_LOW), .CLR_ON_ZERO(C_ZERO)
    ) i_irqc_combiner (
        .clk_i(clk), .rst_ni(rst_n), .src_req_i(req), .reg_wr_i(wr),
        .reg_waddr_i(waddr), .reg_wdata_i(wdata), .reg_raddr_i(raddr),
        .reg_rdata_o(rdata), .irq_o(irq)
    );

    always #10 clk = ~clk;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [NSRC-1:0] eff(input logic [NSRC-1:0] e);
        return (E_LOW ? ~e : e) | ~H_ENA;
    endfunction

    function automatic logic [NSRC-1:0] rd_exp(input logic [1:0] a);
        case (a)
            2'd0:    return m_ena;
            2'd1:    return m_st;
            2'd2:    return (C_ZERO ? 8'hFF : 8'h00) & H_CLR;
            default: return '0;
        endcase
    endfunction

    function automatic string rd_tag(input logic [1:0] a);
        case (a)
            2'd0:    return "R3 enable readback";
            2'd1:    return "R2 status readback";
            default: return "R11 readback";
        endcase
    endfunction

    // Called at a falling edge: drive, check read, update model, cross one rising edge.
    task automatic step(input logic [NSRC-1:0] r, input logic w, input logic [1:0] wa,
                        input logic [NSRC-1:0] wd, input logic [1:0] ra);
        logic [NSRC-1:0] ack;
        req = r; wr = w; waddr = wa; wdata = wd; raddr = ra;
        #1;
        chk(rdata, rd_exp(ra), rd_tag(ra));
        ack = (w && wa == 2'd2) ? ((C_ZERO ? ~wd : wd) & H_CLR) : '0;
        m_irq = |(m_st & eff(m_ena) & VALID);
        for (int b = 0; b < NSRC; b++) begin
            if (!VALID[b])     m_st[b] = 1'b0;
            else if (H_CLR[b]) m_st[b] = (m_st[b] & ~ack[b]) | r[b];
            else               m_st[b] = r[b];
        end
        if (w && wa == 2'd0) m_ena = (wd & H_ENA) | (MASKV & ~H_ENA);
        @(posedge clk);
        @(negedge clk);
        chk({31'd0, irq}, {31'd0, m_irq}, "R9 irq output");
    endtask

    task automatic idle();
        step('0, 1'b0, 2'd0, '0, 2'd1);
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240909));
        m_ena = MASKV; m_st = '0; m_irq = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        raddr = 2'd1; #1; chk(rdata, 8'h00, "R1 status after reset");
        raddr = 2'd0; #1; chk(rdata, 8'hFF, "R1 enable masked after reset");
        chk({31'd0, irq}, 32'd0, "R1 irq after reset");
        @(negedge clk);

        // R7 source 1 has no enable bit: always enabled although register masks all
        step(8'h02, 1'b0, 2'd0, '0, 2'd1);
        idle();
        chk({31'd0, irq}, 32'd1, "R7 unenabled source raises irq");
        step('0, 1'b1, 2'd0, 8'h00, 2'd0);          // write 0 to every enable bit
        raddr = 2'd0; #1; chk(rdata, 8'h02, "R7 absent enable bit keeps masking level");
        step('0, 1'b1, 2'd2, 8'hFD, 2'd1);          // acknowledge source 1 (write 0)
        idle();
        chk({31'd0, irq}, 32'd0, "R4 acknowledge with zero drops irq");

        // R6 source 7 outside valid mask, now enabled
        step(8'h80, 1'b0, 2'd0, '0, 2'd1);
        idle();
        raddr = 2'd1; #1; chk(rdata, 8'h00, "R6 invalid source status");
        chk({31'd0, irq}, 32'd0, "R6 invalid source irq");
        @(negedge clk);

        // R10 two pending, clear one at a time; R4 writing 1 has no effect
        step(8'h11, 1'b0, 2'd0, '0, 2'd1);
        step('0, 1'b1, 2'd2, 8'hFF, 2'd1);
        step('0, 1'b1, 2'd2, 8'hFE, 2'd1);          // ack source 0
        idle();
        chk({31'd0, irq}, 32'd1, "R10 irq held by remaining source");
        // R5 ack and new request same cycle on source 4
        step(8'h10, 1'b1, 2'd2, 8'hEF, 2'd1);
        raddr = 2'd1; #1; chk(rdata, 8'h10, "R5 request wins over acknowledge");
        @(negedge clk);
        step('0, 1'b1, 2'd2, 8'hEF, 2'd1);
        idle();
        chk({31'd0, irq}, 32'd0, "R10 irq falls after last clear");

        // R8 source 6 follows request level; R11 status write ignored
        step(8'h40, 1'b0, 2'd0, '0, 2'd1);
        step('0, 1'b1, 2'd1, 8'hFF, 2'd1);
        raddr = 2'd1; #1; chk(rdata, 8'h00, "R8 level source drops with request");
        @(negedge clk);
        raddr = 2'd2; #1; chk(rdata, 8'hBF, "R11 acknowledge reads idle level");
        @(negedge clk);

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            logic [NSRC-1:0] r;
            r = $urandom & $urandom & $urandom;
            step(r, ($urandom % 4) == 0, 2'($urandom), 8'($urandom), 2'($urandom));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule